// File: doc/BRIEF.md
# Counter-Rotating Ring Transfer Scheduler

This block decides which transfers may enter a ring of twelve nodes. The ring has four one-way channels, each sixteen bytes wide. Channels 0 and 1 carry data clockwise, toward higher node numbers. Channels 2 and 3 carry data counter-clockwise. Every node can raise a request that names a destination node. The scheduler sends each transfer the short way round the ring. It then looks for a channel in that direction on which no running transfer uses any of the same ring segments. When it finds one, it issues a grant and tracks the transfer for its fixed eight-beat life.

Several transfers may share a channel as long as their paths are disjoint, up to a parameterised slot count per channel. A channel may start a new transfer no more than once every three cycles. The whole ring accepts at most one new request per cycle. A node can be the source of only one running transfer and the destination of only one running transfer at a time. Requests that cannot be served are rejected with a pulse.

Top module: `ring_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `grantValid`, `rejValid` and `xferDone` are all zero.
- R2: The clockwise distance is (destination − source) mod 12. A distance of 6 or less is granted on a clockwise channel (0 or 1). A larger distance is granted on a counter-clockwise channel (2 or 3). A distance of exactly 6 goes clockwise.
- R3: A request is rejected if its destination equals its source or is 12 or higher. In that case `rejValid` pulses for one cycle with `rejNode` set to the requester, in the cycle after the request is sampled, and that request never receives a grant.
- R4: A requester holds `reqValid` and its destination until it sees a grant or a reject. When a request can be served, `grantValid` pulses in the cycle after the request is sampled. The pulse carries the source, the destination and the lowest-numbered eligible channel of the chosen direction.
- R5: `xferDone[src]` pulses for exactly one cycle, eight cycles after the grant pulse for that source.
- R6: Segment k joins node k and node (k+1) mod 12. A transfer occupies every segment between its source and its destination along its direction. A channel that has a running transfer on any of the same segments is not eligible. A channel whose running transfers are all segment-disjoint from the request may take it.
- R7: A node that is the source of a running transfer gets no new grant as a source until the cycle after its `xferDone` pulse. The same holds for a node that is the destination of a running transfer, as a destination.
- R8: Two grants on the same channel are at least three cycles apart.
- R9: At most one request is accepted per cycle, counting grants and rejects together. `grantValid` and `rejValid` are never high in the same cycle.
- R10: Each cycle the scheduler serves the first acceptable request, searching upward by node index and wrapping. The search starts at the node after the last node that was granted or rejected. After reset it starts at node 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 12 | Request flag, one bit per node |
| reqDest | input | 48 | Destination node index, 4 bits per node, node n at bits [4n+3:4n] |
| grantValid | output | 1 | Grant pulse |
| grantSrc | output | 4 | Source node of the grant |
| grantDst | output | 4 | Destination node of the grant |
| grantChan | output | 2 | Channel granted (0,1 clockwise; 2,3 counter-clockwise) |
| rejValid | output | 1 | Reject pulse |
| rejNode | output | 4 | Node whose request was rejected |
| xferDone | output | 12 | Completion pulse, one bit per source node |

## Verification
The single acceptance slot each cycle is contested by a reject and a grant together. The bench raises a self-addressed request and a valid request in the same cycle and checks that the reject comes first, alone, and that the grant follows one cycle later. A second clash is between a source that is still busy and a round-robin search that has moved past it. Here a finishing transfer frees two waiting requests at once, and the bench checks that the node found first after the pointer is served first.

// File: rtl/ring_arb_pkg.sv
package ring_arb_pkg;

  // Strobes from control to datapath for the cycle's single acceptance.
  typedef struct packed {
    logic start;   // a transfer is granted and must be loaded into a slot
    logic reject;  // a malformed request is discarded
  } arbStrobe_t;

endpackage

// File: rtl/ring_arb_ctrl.sv
module ring_arb_ctrl
  import ring_arb_pkg::*;
#(
  parameter int NODES    = 12,
  parameter int CHANNELS = 4,
  parameter int MAX_HOPS = 6,
  parameter int IDW      = $clog2(NODES),
  parameter int CHW      = $clog2(CHANNELS)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NODES-1:0]                   reqValid,
  input  logic [NODES*IDW-1:0]               reqDest,
  input  logic [CHANNELS-1:0][NODES-1:0]     chanOcc,
  input  logic [CHANNELS-1:0]                chanRoom,
  input  logic [NODES-1:0]                   srcBusy,
  input  logic [NODES-1:0]                   dstBusy,
  output arbStrobe_t                         strobe,
  output logic [CHW-1:0]                     startChan,
  output logic [IDW-1:0]                     startSrc,
  output logic [IDW-1:0]                     startDst,
  output logic [NODES-1:0]                   startMask,
  output logic                               grantValid,
  output logic [IDW-1:0]                     grantSrc,
  output logic [IDW-1:0]                     grantDst,
  output logic [CHW-1:0]                     grantChan,
  output logic                               rejValid,
  output logic [IDW-1:0]                     rejNode
);

  localparam int HALF = CHANNELS / 2;
  localparam logic [IDW:0] NW = (IDW+1)'(NODES);

  logic [NODES-1:0] nodeBad;
  logic [NODES-1:0] elig;
  logic [NODES-1:0] nodeMask [NODES];
  logic [CHW-1:0]   nodeChan [NODES];
  logic [IDW-1:0]   nodeDest [NODES];

  // Per-node route: direction, hop count, segment mask and channel choice.
  for (genvar n = 0; n < NODES; n++) begin : g_node
    localparam logic [IDW:0] ME = (IDW+1)'(n);
    logic [IDW-1:0]      dest;
    logic [IDW:0]        cwDist;
    logic [IDW:0]        hops;
    logic                useCw;
    logic [IDW-1:0]      startPos;
    logic [NODES-1:0]    base;
    logic [2*NODES-1:0]  wide;
    logic [NODES-1:0]    mask;
    logic [CHANNELS-1:0] chanOk;
    logic [CHW-1:0]      pick;
    logic                bad;

    assign dest = reqDest[n*IDW +: IDW];

    always_comb begin
      bad      = ({1'b0, dest} >= NW) || ({1'b0, dest} == ME);
      cwDist   = ({1'b0, dest} >= ME) ? ({1'b0, dest} - ME) : ({1'b0, dest} + NW - ME);
      useCw    = cwDist <= (IDW+1)'(MAX_HOPS);
      hops     = useCw ? cwDist : (NW - cwDist);
      startPos = useCw ? ME[IDW-1:0] : dest;
      base     = ~({NODES{1'b1}} << hops);
      wide     = {{NODES{1'b0}}, base} << startPos;
      mask     = wide[NODES-1:0] | wide[2*NODES-1:NODES];
      for (int c = 0; c < CHANNELS; c++) begin
        chanOk[c] = ((c < HALF) == useCw) && chanRoom[c] && ((chanOcc[c] & mask) == '0);
      end
      pick = '0;
      for (int c = CHANNELS - 1; c >= 0; c--) begin
        if (chanOk[c]) pick = CHW'(c);
      end
    end

    assign nodeBad[n]  = bad;
    assign nodeMask[n] = mask;
    assign nodeChan[n] = pick;
    assign nodeDest[n] = dest;
    assign elig[n]     = reqValid[n] &&
                         (bad || (!srcBusy[n] && !dstBusy[dest] && (chanOk != '0)));
  end

  // Round-robin search starting after the last accepted node.
  logic [IDW-1:0] lastPtr;
  logic [IDW-1:0] pickNode;
  logic           found;

  always_comb begin
    int idx;
    found    = 1'b0;
    pickNode = '0;
    for (int k = 1; k <= NODES; k++) begin
      idx = (int'(lastPtr) + k) % NODES;
      if (!found && elig[idx]) begin
        found    = 1'b1;
        pickNode = IDW'(idx);
      end
    end
  end

  assign strobe.start  = found && !nodeBad[pickNode];
  assign strobe.reject = found && nodeBad[pickNode];
  assign startChan     = nodeChan[pickNode];
  assign startSrc      = pickNode;
  assign startDst      = nodeDest[pickNode];
  assign startMask     = nodeMask[pickNode];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastPtr    <= IDW'(NODES - 1);
      grantValid <= 1'b0;
      grantSrc   <= '0;
      grantDst   <= '0;
      grantChan  <= '0;
      rejValid   <= 1'b0;
      rejNode    <= '0;
    end else begin
      grantValid <= strobe.start;
      grantSrc   <= startSrc;
      grantDst   <= startDst;
      grantChan  <= startChan;
      rejValid   <= strobe.reject;
      rejNode    <= pickNode;
      if (found) lastPtr <= pickNode;
    end
  end

endmodule

// File: rtl/ring_arb_dp.sv
module ring_arb_dp
  import ring_arb_pkg::*;
#(
  parameter int NODES     = 12,
  parameter int CHANNELS  = 4,
  parameter int SLOTS     = 3,
  parameter int BEATS     = 8,
  parameter int START_GAP = 3,
  parameter int IDW       = $clog2(NODES),
  parameter int CHW       = $clog2(CHANNELS)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  arbStrobe_t                     strobe,
  input  logic [CHW-1:0]                 startChan,
  input  logic [IDW-1:0]                 startSrc,
  input  logic [IDW-1:0]                 startDst,
  input  logic [NODES-1:0]               startMask,
  output logic [CHANNELS-1:0][NODES-1:0] chanOcc,
  output logic [CHANNELS-1:0]            chanRoom,
  output logic [NODES-1:0]               srcBusy,
  output logic [NODES-1:0]               dstBusy,
  output logic [NODES-1:0]               xferDone
);

  localparam int CW = $clog2(BEATS);
  localparam int GW = $clog2(START_GAP + 1);
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [CHANNELS-1:0][NODES-1:0] chSrc, chDst, chDone;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    logic [SLOTS-1:0] act;
    logic [NODES-1:0] sMask [SLOTS];
    logic [IDW-1:0]   sSrc  [SLOTS];
    logic [IDW-1:0]   sDst  [SLOTS];
    logic [CW-1:0]    sCnt  [SLOTS];
    logic [GW-1:0]    gap;
    logic [NODES-1:0] occ, sb, db, dn;
    logic [SW-1:0]    freeIdx;
    logic             hasFree;
    logic             load;

    assign load = strobe.start && (startChan == CHW'(c));

    always_comb begin
      occ = '0; sb = '0; db = '0; dn = '0;
      freeIdx = '0; hasFree = 1'b0;
      for (int s = SLOTS - 1; s >= 0; s--) begin
        if (!act[s]) begin
          hasFree = 1'b1;
          freeIdx = SW'(s);
        end else begin
          occ = occ | sMask[s];
          sb[sSrc[s]] = 1'b1;
          db[sDst[s]] = 1'b1;
          if (sCnt[s] == '0) dn[sSrc[s]] = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        act <= '0;
        gap <= '0;
        for (int s = 0; s < SLOTS; s++) begin
          sMask[s] <= '0;
          sSrc[s]  <= '0;
          sDst[s]  <= '0;
          sCnt[s]  <= '0;
        end
      end else begin
        for (int s = 0; s < SLOTS; s++) begin
          if (load && hasFree && freeIdx == SW'(s)) begin
            act[s]   <= 1'b1;
            sMask[s] <= startMask;
            sSrc[s]  <= startSrc;
            sDst[s]  <= startDst;
            sCnt[s]  <= CW'(BEATS - 1);
          end else if (act[s]) begin
            if (sCnt[s] == '0) act[s] <= 1'b0;
            else               sCnt[s] <= sCnt[s] - 1'b1;
          end
        end
        if (load)            gap <= GW'(START_GAP - 1);
        else if (gap != '0)  gap <= gap - 1'b1;
      end
    end

    assign chanOcc[c]  = occ;
    assign chanRoom[c] = hasFree && (gap == '0);
    assign chSrc[c]    = sb;
    assign chDst[c]    = db;
    assign chDone[c]   = dn;
  end

  logic [NODES-1:0] doneNext;

  always_comb begin
    srcBusy = '0; dstBusy = '0; doneNext = '0;
    for (int c = 0; c < CHANNELS; c++) begin
      srcBusy  = srcBusy | chSrc[c];
      dstBusy  = dstBusy | chDst[c];
      doneNext = doneNext | chDone[c];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) xferDone <= '0;
    else       xferDone <= doneNext;
  end

endmodule

// File: rtl/ring_arb.sv
module ring_arb
  import ring_arb_pkg::*;
#(
  parameter int NODES     = 12,
  parameter int CHANNELS  = 4,
  parameter int MAX_HOPS  = 6,
  parameter int SLOTS     = 3,
  parameter int BEATS     = 8,
  parameter int START_GAP = 3,
  localparam int IDW      = $clog2(NODES),
  localparam int CHW      = $clog2(CHANNELS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NODES-1:0]     reqValid,
  input  logic [NODES*IDW-1:0] reqDest,
  output logic                 grantValid,
  output logic [IDW-1:0]       grantSrc,
  output logic [IDW-1:0]       grantDst,
  output logic [CHW-1:0]       grantChan,
  output logic                 rejValid,
  output logic [IDW-1:0]       rejNode,
  output logic [NODES-1:0]     xferDone
);

  arbStrobe_t                     strobe;
  logic [CHW-1:0]                 startChan;
  logic [IDW-1:0]                 startSrc, startDst;
  logic [NODES-1:0]               startMask;
  logic [CHANNELS-1:0][NODES-1:0] chanOcc;
  logic [CHANNELS-1:0]            chanRoom;
  logic [NODES-1:0]               srcBusy, dstBusy;

  ring_arb_ctrl #(
    .NODES(NODES), .CHANNELS(CHANNELS), .MAX_HOPS(MAX_HOPS), .IDW(IDW), .CHW(CHW)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqDest(reqDest),
    .chanOcc(chanOcc), .chanRoom(chanRoom), .srcBusy(srcBusy), .dstBusy(dstBusy),
    .strobe(strobe), .startChan(startChan), .startSrc(startSrc), .startDst(startDst),
    .startMask(startMask), .grantValid(grantValid), .grantSrc(grantSrc),
    .grantDst(grantDst), .grantChan(grantChan), .rejValid(rejValid), .rejNode(rejNode)
  );

  ring_arb_dp #(
    .NODES(NODES), .CHANNELS(CHANNELS), .SLOTS(SLOTS), .BEATS(BEATS),
    .START_GAP(START_GAP), .IDW(IDW), .CHW(CHW)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startChan(startChan),
    .startSrc(startSrc), .startDst(startDst), .startMask(startMask),
    .chanOcc(chanOcc), .chanRoom(chanRoom), .srcBusy(srcBusy), .dstBusy(dstBusy),
    .xferDone(xferDone)
  );

endmodule

// File: rtl/ring_arb_checker.sv
module ring_arb_checker #(
  parameter int NODES    = 12,
  parameter int CHANNELS = 4,
  parameter int MAX_HOPS = 6,
  parameter int IDW      = $clog2(NODES),
  parameter int CHW      = $clog2(CHANNELS)
) (
  input logic               clk,
  input logic               rstN,
  input logic [NODES-1:0]   reqValid,
  input logic               grantValid,
  input logic [IDW-1:0]     grantSrc,
  input logic [IDW-1:0]     grantDst,
  input logic [CHW-1:0]     grantChan,
  input logic               rejValid
);

  function automatic int cwSteps(logic [IDW-1:0] s, logic [IDW-1:0] d);
    return (int'(d) + NODES - int'(s)) % NODES;
  endfunction

  AST_SINGLE_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    !(grantValid && rejValid)); // R9

  AST_NO_SELF_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (grantSrc != grantDst)); // R3

  AST_GRANT_HAD_REQ: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && $past(rstN) |-> (($past(reqValid) >> grantSrc) & 1) == 1); // R4

  AST_SHORT_WAY: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> ((cwSteps(grantSrc, grantDst) <= MAX_HOPS) == (int'(grantChan) < CHANNELS/2))); // R2

  AST_GAP_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |=> !(grantValid && grantChan == $past(grantChan))); // R8

  AST_GAP_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && $past(grantValid, 2) && $past(rstN, 2) |-> grantChan != $past(grantChan, 2)); // R8

endmodule

bind ring_arb ring_arb_checker #(
  .NODES(NODES), .CHANNELS(CHANNELS), .MAX_HOPS(MAX_HOPS), .IDW(IDW), .CHW(CHW)
) i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .grantValid(grantValid),
  .grantSrc(grantSrc), .grantDst(grantDst), .grantChan(grantChan), .rejValid(rejValid)
);

// File: tb/test_ring_arb.sv
module test_ring_arb;

  localparam int NODES = 12;
  localparam int IDW   = 4;
  localparam int CHW   = 2;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic [NODES-1:0]     reqValid = '0;
  logic [NODES*IDW-1:0] reqDest = '0;
  logic                 grantValid, rejValid;
  logic [IDW-1:0]       grantSrc, grantDst, rejNode;
  logic [CHW-1:0]       grantChan;
  logic [NODES-1:0]     xferDone;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  ring_arb i_ring_arb (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqDest(reqDest),
    .grantValid(grantValid), .grantSrc(grantSrc), .grantDst(grantDst),
    .grantChan(grantChan), .rejValid(rejValid), .rejNode(rejNode), .xferDone(xferDone)
  );

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Advance to the next falling edge and retire granted/rejected requests.
  task automatic tick();
    @(negedge clk);
    if (grantValid) reqValid[grantSrc] = 1'b0;
    if (rejValid)   reqValid[rejNode]  = 1'b0;
  endtask

  task automatic setReq(int n, int d);
    reqDest[n*IDW +: IDW] = IDW'(d);
    reqValid[n] = 1'b1;
  endtask

  task automatic doReset();
    reqValid = '0;
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic expectGrant(string tag, int s, int d, int ch);
    check({tag, " grantValid"}, int'(grantValid), 1);
    check({tag, " grantSrc"},   int'(grantSrc), s);
    check({tag, " grantDst"},   int'(grantDst), d);
    check({tag, " grantChan"},  int'(grantChan), ch);
    check({tag, " rejValid"},   int'(rejValid), 0);
  endtask

  task automatic expectQuiet(string tag);
    check({tag, " grantValid"}, int'(grantValid), 0);
    check({tag, " rejValid"},   int'(rejValid), 0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    @(negedge clk);
    expectQuiet("R1 in reset");
    check("R1 xferDone in reset", int'(xferDone), 0);
    rstN = 1'b1;
    tick();
    expectQuiet("R1 after release");
    check("R1 xferDone after release", int'(xferDone), 0);
  endtask

  task automatic testSingle();
    doReset();
    setReq(2, 5);
    tick();
    expectGrant("R4 single 2->5", 2, 5, 0);
    for (int i = 2; i <= 8; i++) begin
      tick();
      check("R5 no early done", int'(xferDone), 0);
    end
    tick();
    check("R5 done pulse", int'(xferDone), 1 << 2);
    tick();
    check("R5 done one cycle", int'(xferDone), 0);
  endtask

  task automatic testDirection();
    doReset();
    setReq(3, 9);
    tick();
    expectGrant("R2 tie distance 6 clockwise", 3, 9, 0);
    doReset();
    setReq(3, 10);
    tick();
    expectGrant("R2 distance 7 counter-clockwise", 3, 10, 2);
    doReset();
    setReq(6, 0);
    tick();
    expectGrant("R2 wrap distance 6 clockwise", 6, 0, 0);
  endtask

  task automatic testReject();
    doReset();
    setReq(4, 4);
    tick();
    check("R3 self reject pulse", int'(rejValid), 1);
    check("R3 self reject node", int'(rejNode), 4);
    check("R3 self no grant", int'(grantValid), 0);
    setReq(5, 13);
    tick();
    check("R3 range reject pulse", int'(rejValid), 1);
    check("R3 range reject node", int'(rejNode), 5);
    tick();
    expectQuiet("R3 nothing after rejects");
  endtask

  task automatic testOverlap();
    doReset();
    setReq(0, 3);
    tick();
    expectGrant("R6 first 0->3", 0, 3, 0);
    tick();
    tick();
    setReq(1, 2);
    tick();
    expectGrant("R6 overlap moves to channel 1", 1, 2, 1);
    setReq(4, 5);
    tick();
    expectGrant("R6 disjoint shares channel 0", 4, 5, 0);
  endtask

  task automatic testPacing();
    doReset();
    setReq(0, 1);
    setReq(2, 3);
    setReq(4, 5);
    tick();
    expectGrant("R8 first start", 0, 1, 0);
    tick();
    expectGrant("R8 second on channel 1", 2, 3, 1);
    tick();
    expectQuiet("R8 both clockwise channels paced");
    tick();
    expectGrant("R8 channel 0 after three cycles", 4, 5, 0);
  endtask

  task automatic testPortLimit();
    doReset();
    setReq(0, 2);
    tick();
    expectGrant("R7 first 0->2", 0, 2, 0);
    setReq(0, 4);
    setReq(5, 2);
    for (int i = 2; i <= 8; i++) begin
      tick();
      expectQuiet("R7 source and destination busy");
    end
    tick();
    expectQuiet("R7 busy in done cycle");
    check("R7 done of node 0", int'(xferDone), 1);
    tick();
    expectGrant("R10 node after pointer first", 5, 2, 2);
    tick();
    expectGrant("R7 source reused after done", 0, 4, 0);
  endtask

  task automatic testRoundRobin();
    doReset();
    setReq(3, 4);
    setReq(7, 6);
    setReq(10, 9);
    tick();
    expectGrant("R10 order first", 3, 4, 0);
    tick();
    expectGrant("R10 order second", 7, 6, 2);
    tick();
    expectGrant("R10 order third", 10, 9, 3);
    setReq(2, 1);
    setReq(11, 0);
    tick();
    expectGrant("R10 node 11 before node 2", 11, 0, 0);
    tick();
    expectGrant("R10 node 2 next", 2, 1, 2);
  endtask

  task automatic testContend();
    doReset();
    setReq(4, 4);
    setReq(5, 6);
    tick();
    check("R9 reject wins slot", int'(rejValid), 1);
    check("R9 no grant alongside reject", int'(grantValid), 0);
    tick();
    expectGrant("R9 grant next cycle", 5, 6, 0);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testSingle();
    testDirection();
    testReject();
    testOverlap();
    testPacing();
    testPortLimit();
    testRoundRobin();
    testContend();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule